// File: doc/BRIEF.md
# Delay-Code Programming Port

This block holds the 8-bit code that sets a programmable delay element and gives two ways to load it. In parallel mode eight input pins pass through a transparent latch into the active code. In serial mode a separate shadow register is loaded from the active code and shifted through a serial clock and data input. Its old contents leave on a serial output. Because the outputs can be chained device to device, and looping the output back restores the original value, the code can be read without changing it.

All inputs are sampled by a system clock through a two-stage synchronizer. The serial clock, serial data in and serial data out reuse three of the parallel pins: pin 1 is the clock, pin 2 is data in, and pin 0 is data out. The active code feeds the delay core directly. A one-cycle strobe marks each activation that changes the code.

Top module: `dly_code_port`

## Requirements
- R1: `prog_serial` low selects parallel loading and high selects serial loading; `sdo_oe` is high exactly while serial loading is selected.
- R2: In parallel mode, while `latch_en` is high, `code` follows `pins_in[7:0]` (bit 7 the most significant).
- R3: In parallel mode, while `latch_en` is low, `code` holds its value whatever `pins_in` does.
- R4: In serial mode, while `latch_en` is high, shifting does not alter `code`.
- R5: In serial mode, each rising edge on `pins_in[1]` with `latch_en` high shifts `pins_in[2]` into the shadow register's least significant bit, so a byte sent most significant bit first lands in order.
- R6: In serial mode, a falling edge of `latch_en` copies the shadow register into `code`.
- R7: In serial mode, a rising edge of `latch_en` loads the shadow register from `code`, so `sdo` presents bit 7 of the code. Each rising serial clock then presents the next lower bit, and the bits shifted out are the previous contents, most significant first.
- R8: In serial mode with `latch_en` low, serial clock edges and changes on the pins do not alter `code`.
- R9: `code_changed` pulses high for exactly one cycle after an update that gives `code` a new value, and stays low when an activation leaves the value the same, as after a loop-back read.
- R10: Synchronous active-high reset clears `code` to zero and holds `code_changed` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_serial | input | 1 | Loading mode: 0 parallel, 1 serial |
| latch_en | input | 1 | Latch enable / serial transfer window |
| pins_in | input | 8 | Parallel code pins; [1] serial clock, [2] serial data in |
| sdo | output | 1 | Serial data out (shares pin 0) |
| sdo_oe | output | 1 | Drive enable for the shared serial output pin |
| code | output | 8 | Active delay code to the delay core |
| code_changed | output | 1 | One-cycle strobe when the active code takes a new value |

## Verification
The bench goes after the hold cases first. A design that stayed transparent with the latch closed, or that let shifting reach the active code, would move the delay in the middle of a transfer. A loop-back read checks that restoration gives the same code and raises no strobe; a design that cleared the shadow register, or pulsed on every activation, would report false changes. Capturing the serial output during a write shows whether the bits leave most significant first and are really the prior code, which daisy-chaining depends on.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
    localparam int CODE_W    = 8;
    localparam int SDO_PIN   = 0;
    localparam int SCLK_PIN  = 1;
    localparam int SDI_PIN   = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        PROG_PARALLEL = 1'b0,
        PROG_SERIAL   = 1'b1
    } prog_mode_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_t;

    function automatic code_t shift_in(code_t cur, logic bit_in);
        return {cur[CODE_W-2:0], bit_in};
    endfunction
endpackage

// File: rtl/dcp_sync.sv
module dcp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/dcp_edge.sv
module dcp_edge
    import dcp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  lvl,
    output edge_t ev
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    always_comb begin
        ev.level = lvl;
        ev.rise  = lvl & ~prev;
        ev.fall  = ~lvl & prev;
    end
endmodule

// File: rtl/dcp_shadow.sv
module dcp_shadow
    import dcp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  code_t load_val,
    input  logic  shift,
    input  logic  sdi,
    output code_t q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= shift_in(q, sdi);
    end
endmodule

// File: rtl/dly_code_port.sv
module dly_code_port
    import dcp_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_serial,
    input  logic              latch_en,
    input  logic [CODE_W-1:0] pins_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [CODE_W-1:0] code,
    output logic              code_changed
);
    localparam int RAW_W = CODE_W + 2;

    logic [RAW_W-1:0] raw_in, syn;
    prog_mode_e       mode_s;
    code_t            pins_s;
    edge_t            le_ev, sclk_ev;
    code_t            shadow, active, nxt;
    logic             ser_s, le_lvl;
    logic             sh_load, sh_shift;

    assign raw_in = {prog_serial, latch_en, pins_in};

    dcp_sync #(.W(RAW_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn)
    );

    assign mode_s = prog_mode_e'(syn[CODE_W+1]);
    assign pins_s = syn[CODE_W-1:0];
    assign ser_s  = (mode_s == PROG_SERIAL);

    dcp_edge u_le_edge (
        .clk (clk),
        .rst (rst),
        .lvl (syn[CODE_W]),
        .ev  (le_ev)
    );

    dcp_edge u_sclk_edge (
        .clk (clk),
        .rst (rst),
        .lvl (pins_s[SCLK_PIN]),
        .ev  (sclk_ev)
    );

    assign le_lvl   = le_ev.level;
    assign sh_load  = ser_s & le_ev.rise;
    assign sh_shift = ser_s & le_ev.level & sclk_ev.rise & ~le_ev.rise;

    dcp_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .load_val (active),
        .shift    (sh_shift),
        .sdi      (pins_s[SDI_PIN]),
        .q        (shadow)
    );

    always_comb begin
        nxt = active;
        if (!ser_s && le_ev.level)     nxt = pins_s;
        else if (ser_s && le_ev.fall)  nxt = shadow;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active       <= '0;
            code_changed <= 1'b0;
        end else begin
            active       <= nxt;
            code_changed <= (nxt != active);
        end
    end

    assign code   = active;
    assign sdo    = shadow[CODE_W-1];
    assign sdo_oe = ser_s;
endmodule

// File: rtl/dly_code_port_chk.sv
module dly_code_port_chk
    import dcp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ser_s,
    input logic              le_lvl,
    input logic [CODE_W-1:0] code,
    input logic              code_changed
);
    assert_strobe_means_new_R9: assert property (@(posedge clk) disable iff (rst)
        code_changed |-> (code != $past(code)));

    assert_new_means_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        (code != $past(code)) |-> code_changed);

    assert_shift_keeps_code_R4: assert property (@(posedge clk) disable iff (rst)
        (ser_s && le_lvl) |=> $stable(code));

    assert_latch_closed_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!ser_s && !le_lvl) |=> $stable(code));

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (code == '0 && !code_changed));
endmodule

bind dly_code_port dly_code_port_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ser_s        (ser_s),
    .le_lvl       (le_lvl),
    .code         (code),
    .code_changed (code_changed)
);

// File: tb/dly_code_port_test.sv
module dly_code_port_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_serial = 1'b0;
    logic       latch_en = 1'b0;
    logic [7:0] drv = 8'h00;
    logic       loopback = 1'b0;
    logic [7:0] pins_in;
    logic       sdo, sdo_oe, code_changed;
    logic [7:0] code;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    int run_len = 0;
    int max_run = 0;

    always #4 clk = ~clk;

    assign pins_in = {drv[7:3], (loopback ? sdo : drv[2]), drv[1:0]};

    dly_code_port uut (
        .clk          (clk),
        .rst          (rst),
        .prog_serial  (prog_serial),
        .latch_en     (latch_en),
        .pins_in      (pins_in),
        .sdo          (sdo),
        .sdo_oe       (sdo_oe),
        .code         (code),
        .code_changed (code_changed)
    );

    always @(posedge clk) begin
        if (!rst && code_changed) begin
            strobes <= strobes + 1;
            run_len <= run_len + 1;
            if (run_len + 1 > max_run) max_run <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    // {latch_en, pins, expected code}
    localparam logic [16:0] PAR_VEC [6] = '{
        {1'b1, 8'h5A, 8'h5A},
        {1'b1, 8'hFF, 8'hFF},
        {1'b0, 8'h12, 8'hFF},
        {1'b0, 8'h00, 8'hFF},
        {1'b1, 8'h81, 8'h81},
        {1'b1, 8'h00, 8'h00}
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ser_shift(input logic [7:0] v, output logic [7:0] seen);
        for (int i = 7; i >= 0; i--) begin
            drv[2] = v[i];
            wait_cyc(4);
            seen[i] = sdo;
            drv[1] = 1'b1;
            wait_cyc(4);
            drv[1] = 1'b0;
            wait_cyc(4);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] seen;
        int base;
        wait_cyc(3);
        check("R10 reset code", code, 8'h00);
        check("R10 reset strobe", code_changed, 1'b0);
        rst = 1'b0;
        wait_cyc(6);
        check("R1 parallel oe", sdo_oe, 1'b0);

        // R2/R3 parallel vector walk
        for (int k = 0; k < 6; k++) begin
            latch_en = PAR_VEC[k][16];
            drv      = PAR_VEC[k][15:8];
            wait_cyc(6);
            check(PAR_VEC[k][16] ? "R2 transparent" : "R3 hold", code, PAR_VEC[k][7:0]);
        end
        check("R9 parallel strobe count", strobes, 4);

        // enter serial mode with latch closed
        latch_en = 1'b0;
        drv = 8'h00;
        wait_cyc(6);
        prog_serial = 1'b1;
        wait_cyc(6);
        check("R1 serial oe", sdo_oe, 1'b1);

        // R5/R6 write A5; R7 previous contents 00 shift out
        latch_en = 1'b1;
        wait_cyc(6);
        ser_shift(8'hA5, seen);
        check("R7 shifted-out old code", seen, 8'h00);
        check("R4 code held while shifting", code, 8'h00);
        latch_en = 1'b0;
        wait_cyc(6);
        check("R6 activation on fall", code, 8'hA5);
        check("R9 strobe on new code", strobes, 5);

        // R7 readout starts with bit 7, then daisy-chain write 3C
        latch_en = 1'b1;
        wait_cyc(6);
        check("R7 msb on latch rise", sdo, 1'b1);
        ser_shift(8'h3C, seen);
        check("R7 chained shift-out", seen, 8'hA5);
        check("R4 code held while shifting", code, 8'hA5);
        latch_en = 1'b0;
        wait_cyc(6);
        check("R5 msb-first load", code, 8'h3C);

        // loop-back read restores value, no strobe
        base = strobes;
        loopback = 1'b1;
        latch_en = 1'b1;
        wait_cyc(6);
        ser_shift(8'hFF, seen);
        check("R7 readback value", seen, 8'h3C);
        latch_en = 1'b0;
        wait_cyc(6);
        loopback = 1'b0;
        check("R9 readback keeps code", code, 8'h3C);
        check("R9 readback no strobe", strobes, base);

        // R8 clock and pins ignored with latch closed
        drv = 8'hFD;
        for (int j = 0; j < 4; j++) begin
            drv[1] = 1'b1; wait_cyc(4);
            drv[1] = 1'b0; wait_cyc(4);
        end
        drv = 8'hC1;
        wait_cyc(6);
        check("R8 serial idle ignored", code, 8'h3C);
        check("R8 no strobe", strobes, base);

        // back to parallel with latch closed
        prog_serial = 1'b0;
        wait_cyc(6);
        check("R1 parallel oe off", sdo_oe, 1'b0);
        check("R3 hold after mode return", code, 8'h3C);
        check("R9 strobe width", max_run, 1);

        // reset mid-run
        @(negedge clk);
        rst = 1'b1;
        wait_cyc(2);
        check("R10 reset mid-run code", code, 8'h00);
        check("R10 reset mid-run strobe", code_changed, 1'b0);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule